// File: doc/BRIEF.md
# Stop-mode pin wake-up controller

This block puts the device into a deep stop state in which the main oscillator and the sub-oscillator are both switched off. It brings the device out of that state when an enabled port pin is driven low. The core raises a stop request. The controller still allows one more instruction-fetch slot, which the core fills with a no-operation. It then drops both oscillator enables and the core clock enable.

Eight port pins can act as wake sources: four from port C and four from port D. Software chooses which of them are live through a write-only 8-bit mask. A falling edge on a live pin is caught by a per-pin capture flop that is clocked by the pin itself, so detection works with every clock stopped. The captures are ORed into a wake request.

On wake, both oscillators restart at once. The core clock stays gated for a fixed settle count, and after that the captures are cleared.

Top module: `stop_wake_ctrl`

## Requirements
- R1: The wake mask is 8 bits wide and has no read path. It is loaded from `mask_wdata_i` when `mask_we_i` is high in the run state. A write made in any other state leaves the mask unchanged.
- R2: Mask bits 0 to 3 make port C pins 0 to 3 (`port_c_i[3:0]`) wake sources.
- R3: Mask bits 4 to 7 make port D pins 0 to 3 (`port_d_i[3:0]`) wake sources.
- R4: Only a high-to-low transition on a pin whose mask bit is 1 ends the stop state. Rising edges, steady levels and falling edges on pins whose mask bit is 0 leave the device stopped.
- R5: A stop request accepted in the run state keeps the core clock and both oscillators running for one further cycle (the fetch slot). From the cycle after that, `main_osc_en_o`, `sub_osc_en_o` and `core_clk_en_o` are all 0 and `stopped_o` is 1.
- R6: In the cycle after a wake is recognised, both oscillator enables return to 1. `core_clk_en_o` stays 0 for exactly 16 cycles (parameter `SETTLE_CYCLES`) and then returns to 1 in the run state.
- R7: A falling edge on an enabled pin inside the cycle in which the stop request is raised is kept, and it wakes the device as soon as the stop state is reached.
- R8: A stop request raised outside the run state is ignored.
- R9: After reset the block is in the run state with every clock enable at 1, `stopped_o` at 0 and the mask cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock for the control state machine |
| rst_i | input | 1 | Synchronous active-high reset |
| mask_we_i | input | 1 | Immediate write strobe for the wake mask |
| mask_wdata_i | input | 8 | Immediate value for the wake mask |
| stop_req_i | input | 1 | Stop request from the core |
| port_c_i | input | 4 | Port C pins usable as wake sources |
| port_d_i | input | 4 | Port D pins usable as wake sources |
| main_osc_en_o | output | 1 | Main oscillator enable |
| sub_osc_en_o | output | 1 | Sub-oscillator enable |
| core_clk_en_o | output | 1 | Core clock gate enable |
| stopped_o | output | 1 | High while the device sits in the stop state |

## Verification
The hardest case to reach is a pin edge that lands in the same cycle as the stop request. At that moment the capture flop is armed only through the combinational request path. The bench raises the request at a falling clock edge and drops the pin a nanosecond later, inside that cycle. It then confirms that the wake follows directly after the fetch slot. Edges on masked pins, rising edges and mask writes made while stopped are applied between clock edges, and every cycle is compared against a behavioural model.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam int PIN_COUNT     = 8;
    localparam int PORT_WIDTH    = 4;
    localparam int SETTLE_CYCLES = 16;
    localparam int SETTLE_W      = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;

    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_FETCH  = 2'd1,
        PS_HALT   = 2'd2,
        PS_SETTLE = 2'd3
    } pwr_state_t;

    typedef struct packed {
        logic main_osc;
        logic sub_osc;
        logic core_clk;
        logic halted;
    } clk_ctl_t;

    function automatic clk_ctl_t decode_clocks(pwr_state_t s);
        clk_ctl_t c;
        c.main_osc = (s != PS_HALT);
        c.sub_osc  = (s != PS_HALT);
        c.core_clk = (s == PS_RUN) || (s == PS_FETCH);
        c.halted   = (s == PS_HALT);
        return c;
    endfunction

endpackage

// File: rtl/wake_edge_capture.sv
module wake_edge_capture #(
    parameter int N = 8
) (
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] mask_i,
    input  logic         arm_i,
    input  logic         clr_i,
    output logic [N-1:0] cap_o
);
    // One flop per pin, clocked by the pin's own falling edge so that
    // capture needs no running clock; cleared asynchronously by clr_i.
    for (genvar k = 0; k < N; k++) begin : g_pin
        logic hit_q;
        always_ff @(negedge pin_i[k] or posedge clr_i) begin
            if (clr_i) hit_q <= 1'b0;
            else       hit_q <= hit_q | (arm_i & mask_i[k]);
        end
        assign cap_o[k] = hit_q;
    end
endmodule

// File: rtl/wake_settle_fsm.sv
module wake_settle_fsm
    import wake_pkg::*;
#(
    parameter int SETTLE = SETTLE_CYCLES,
    parameter int CNT_W  = SETTLE_W
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       stop_req_i,
    input  logic       wake_i,
    output pwr_state_t state_o,
    output logic       clr_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

    pwr_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             clr_q;
    logic             settle_done;

    assign settle_done = (state_q == PS_SETTLE) && (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN:    if (stop_req_i) state_d = PS_FETCH;
            PS_FETCH:  state_d = PS_HALT;
            PS_HALT:   if (wake_i) state_d = PS_SETTLE;
            PS_SETTLE: if (settle_done) state_d = PS_RUN;
            default:   state_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PS_RUN;
            cnt_q   <= '0;
            clr_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            clr_q   <= settle_done;
            if (state_q == PS_SETTLE) cnt_q <= cnt_q + 1'b1;
            else                      cnt_q <= '0;
        end
    end

    assign state_o = state_q;
    assign clr_o   = clr_q;
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import wake_pkg::*;
#(
    parameter int PORT_W = PORT_WIDTH,
    parameter int SETTLE = SETTLE_CYCLES
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              mask_we_i,
    input  logic [2*PORT_W-1:0] mask_wdata_i,
    input  logic              stop_req_i,
    input  logic [PORT_W-1:0] port_c_i,
    input  logic [PORT_W-1:0] port_d_i,
    output logic              main_osc_en_o,
    output logic              sub_osc_en_o,
    output logic              core_clk_en_o,
    output logic              stopped_o
);
    localparam int NPIN = 2 * PORT_W;
    localparam int CW   = (SETTLE > 1) ? $clog2(SETTLE) : 1;

    pwr_state_t      state;
    clk_ctl_t        ctl;
    logic [NPIN-1:0] mask_q;
    logic [NPIN-1:0] pins;
    logic [NPIN-1:0] cap;
    logic            arm;
    logic            clr;
    logic            wake;

    // port C occupies the low half of the mask, port D the high half
    assign pins = {port_d_i, port_c_i};

    always_ff @(posedge clk_i) begin
        if (rst_i)                              mask_q <= '0;
        else if (mask_we_i && state == PS_RUN)  mask_q <= mask_wdata_i;
    end

    // armed from the request cycle onward so a same-cycle edge is kept
    assign arm  = (state != PS_RUN) || stop_req_i;
    assign wake = |cap;

    wake_edge_capture #(.N(NPIN)) u_cap (
        .pin_i  (pins),
        .mask_i (mask_q),
        .arm_i  (arm),
        .clr_i  (clr),
        .cap_o  (cap)
    );

    wake_settle_fsm #(.SETTLE(SETTLE), .CNT_W(CW)) u_fsm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .stop_req_i (stop_req_i),
        .wake_i     (wake),
        .state_o    (state),
        .clr_o      (clr)
    );

    assign ctl           = decode_clocks(state);
    assign main_osc_en_o = ctl.main_osc;
    assign sub_osc_en_o  = ctl.sub_osc;
    assign core_clk_en_o = ctl.core_clk;
    assign stopped_o     = ctl.halted;
endmodule

// File: rtl/stop_wake_ctrl_checker.sv
module stop_wake_ctrl_checker
    import wake_pkg::*;
(
    input logic       clk_i,
    input logic       rst_i,
    input logic       stop_req_i,
    input pwr_state_t state,
    input logic [7:0] mask_q,
    input logic [7:0] cap,
    input logic       main_osc_en_o,
    input logic       sub_osc_en_o,
    input logic       core_clk_en_o,
    input logic       stopped_o
);
    a_r1_mask_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        (state != PS_RUN) |=> $stable(mask_q));

    a_r4_masked_never_captured: assert property (@(posedge clk_i) disable iff (rst_i)
        (cap & ~mask_q) == '0);

    a_r5_stopped_all_off: assert property (@(posedge clk_i) disable iff (rst_i)
        stopped_o |-> (!main_osc_en_o && !sub_osc_en_o && !core_clk_en_o));

    a_r5_fetch_slot: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == PS_RUN && stop_req_i) |=> (core_clk_en_o && main_osc_en_o) ##1 stopped_o);

    a_r6_wake_restarts_osc: assert property (@(posedge clk_i) disable iff (rst_i)
        (stopped_o && cap != '0) |=> (main_osc_en_o && sub_osc_en_o && !core_clk_en_o));

    a_r6_core_after_osc: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(core_clk_en_o) |-> $past(main_osc_en_o));

    a_r8_no_stop_outside_run: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == PS_SETTLE && stop_req_i) |=> !stopped_o);
endmodule

bind stop_wake_ctrl stop_wake_ctrl_checker u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .stop_req_i    (stop_req_i),
    .state         (state),
    .mask_q        (mask_q),
    .cap           (cap),
    .main_osc_en_o (main_osc_en_o),
    .sub_osc_en_o  (sub_osc_en_o),
    .core_clk_en_o (core_clk_en_o),
    .stopped_o     (stopped_o)
);

// File: tb/stop_wake_ctrl_tb.sv
`timescale 1ns/1ps
module stop_wake_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       mask_we_i = 1'b0;
    logic [7:0] mask_wdata_i = '0;
    logic       stop_req_i = 1'b0;
    logic [3:0] port_c_i = 4'hF;
    logic [3:0] port_d_i = 4'hF;
    logic       main_osc_en_o, sub_osc_en_o, core_clk_en_o, stopped_o;

    int vectors = 0;
    int errors  = 0;
    string tag = "R9";

    // behavioural model: 0 run, 1 fetch slot, 2 stopped, 3 settling
    int   m_st  = 0;
    int   m_cnt = 0;
    logic [7:0] m_mask = '0;
    bit   m_cap = 0;

    always #2.5 clk = ~clk;

    stop_wake_ctrl u_dut (
        .clk_i(clk), .rst_i(rst_i), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
        .stop_req_i(stop_req_i), .port_c_i(port_c_i), .port_d_i(port_d_i),
        .main_osc_en_o(main_osc_en_o), .sub_osc_en_o(sub_osc_en_o),
        .core_clk_en_o(core_clk_en_o), .stopped_o(stopped_o));

    always @(posedge clk) begin
        if (rst_i) begin
            m_st = 0; m_cnt = 0; m_mask = '0; m_cap = 0;
        end else begin
            case (m_st)
                0: begin
                    if (mask_we_i) m_mask = mask_wdata_i;
                    if (stop_req_i) m_st = 1;
                end
                1: m_st = 2;
                2: if (m_cap) begin m_st = 3; m_cnt = 0; end
                default: begin
                    if (m_cnt == 15) begin m_st = 0; m_cap = 0; end
                    else m_cnt++;
                end
            endcase
        end
    end

    task automatic tick();
        logic [3:0] exp;
        @(negedge clk);
        exp[3] = (m_st != 2);
        exp[2] = (m_st != 2);
        exp[1] = (m_st <= 1);
        exp[0] = (m_st == 2);
        vectors++;
        if ({main_osc_en_o, sub_osc_en_o, core_clk_en_o, stopped_o} !== exp) begin
            errors++;
            $display("FAIL %s: {main,sub,core,stopped} actual %b expected %b at %0t",
                     tag, {main_osc_en_o, sub_osc_en_o, core_clk_en_o, stopped_o}, exp, $time);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // drive all eight pins {D,C}; model captures enabled falling edges when armed
    task automatic set_pins(logic [7:0] v);
        logic [7:0] old;
        #1;
        old = {port_d_i, port_c_i};
        {port_d_i, port_c_i} = v;
        if (((old & ~v & m_mask) != '0) && (m_st != 0 || stop_req_i)) m_cap = 1;
    endtask

    task automatic write_mask(logic [7:0] v);
        mask_we_i = 1'b1; mask_wdata_i = v;
        tick();
        mask_we_i = 1'b0;
    endtask

    task automatic do_stop();
        stop_req_i = 1'b1;
        tick();
        stop_req_i = 1'b0;
        ticks(3);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        ticks(3);
        rst_i = 1'b0;
        tag = "R9"; ticks(2);

        // R2: port C pin 0 wakes, full settle timing (R6)
        tag = "R2"; write_mask(8'h01);
        do_stop();
        set_pins(8'hFE); tag = "R6"; ticks(20);
        set_pins(8'hFF); tick();

        // R3: port D pin 2 wakes
        tag = "R3"; write_mask(8'h40);
        do_stop(); ticks(2);
        set_pins(8'hBF); ticks(20);
        set_pins(8'hFF); tick();

        // R4: masked pin edges and rising edges do not wake
        tag = "R4"; write_mask(8'h02);
        set_pins(8'hFD); tick();          // pre-low in run, not armed
        do_stop();
        set_pins(8'hFF); ticks(3);        // rising edge on enabled pin
        set_pins(8'hFE); ticks(3);        // falling on masked C0
        set_pins(8'hEE); ticks(3);        // falling on masked D0
        // R1: write while stopped ignored
        tag = "R1"; mask_we_i = 1'b1; mask_wdata_i = 8'hFF; tick(); mask_we_i = 1'b0;
        set_pins(8'hFF); tick();
        set_pins(8'h7F); ticks(3);        // D3 masked in live mask 0x02
        tag = "R4"; set_pins(8'h7D); ticks(20);   // enabled C1 falls
        // R8: stop request during settle ignored
        tag = "R8"; write_mask(8'h08);
        set_pins(8'hFF); tick();
        do_stop();
        set_pins(8'hF7); ticks(2);
        stop_req_i = 1'b1; ticks(4); stop_req_i = 1'b0; ticks(16);
        set_pins(8'hFF); tick();

        // R7: edge in the same cycle as the stop request
        tag = "R7"; write_mask(8'h20);
        stop_req_i = 1'b1;
        set_pins(8'hDF);
        tick(); stop_req_i = 1'b0;
        ticks(22);
        set_pins(8'hFF); tick();

        // R5: fetch slot visible, then stays stopped without an edge
        tag = "R5"; write_mask(8'h00);
        do_stop(); ticks(5);

        // reset out of stop
        tag = "R9"; rst_i = 1'b1; ticks(2); rst_i = 1'b0; ticks(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule